// File: doc/BRIEF.md
# UART Register File with Divisor Latch

This block is the byte-wide, memory-mapped register file of a 16550-style serial controller. A host reaches eight registers through a 3-bit offset and separate read and write strobes. Read data is combinational on the offset. Writes take effect at the clock edge.

The top bit of the line control register is a latch-access bit. It remaps offsets 0 and 1 from the data and interrupt-enable registers onto the two bytes of a 16-bit baud divisor. The divisor drives a tick generator whose pulse rate is sixteen times the serial bit rate. External transmit and receive shifter engines exchange bytes with the block through single-entry holding registers and valid/ready handshakes. The line status register reports the state of both holding registers.

Top module: `uart_regfile`

## Requirements
- R1: After reset, offsets 1 (interrupt enable), 3 (line control), 4 (modem control) and 7 (scratch) read 0x00. Offset 2 (interrupt status) reads 0x01. Offset 5 (line status) reads 0x60 while `tx_idle_i` is 1. `tx_valid_o` is 0 and `rx_ready_o` is 1.
- R2: When line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. The transmit holding register and interrupt enable are then left untouched. When bit 7 is 0, offset 1 is interrupt enable and a write to offset 0 goes to the transmit holding register.
- R3: A receive byte is taken when `rx_valid_i` and `rx_ready_o` are both 1. Line status bit 0 is then 1 and `rx_ready_o` is 0 until offset 0 is read with `rd_i` while bit 7 of line control is 0. That read returns the byte, and bit 0 is clear in the following cycle.
- R4: A write to offset 0 (bit 7 clear) while line status bit 5 is 1 loads the byte. `tx_valid_o` goes to 1 with `tx_data_o` equal to the byte and bit 5 goes to 0. A write while bit 5 is 0 is ignored. The cycle with `tx_valid_o` and `tx_ready_i` both 1 empties the register.
- R5: Line status bit 6 is 1 only when bit 5 is 1 and `tx_idle_i` is 1. Line status bits 1–4 and 7 read 0.
- R6: With a divisor N ≥ 1, `baud_tick_o` is a one-cycle pulse. It is first high in the N-th cycle after the edge that wrote either divisor byte, and then every N cycles.
- R7: With divisor 0, `baud_tick_o` stays 0. The divisor is 0 after reset.
- R8: Offset 2 reads 0x04 when interrupt enable bit 0 is set and a received byte is waiting. Otherwise it reads 0x02 when enable bit 1 is set and the transmit holding register is empty. Otherwise it reads 0x01.
- R9: Scratch (offset 7), modem control (offset 4) and line control (offset 3) read back the last byte written to them. The scratch register affects nothing else.
- R10: Writes to offset 2 (FIFO control), offset 5 and offset 6 change no readable state.
- R11: Offset 6 reads `{modem_i, 4'h0}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| tx_data_o | output | 8 | Byte offered to the transmit shifter |
| tx_valid_o | output | 1 | Transmit holding register full |
| tx_ready_i | input | 1 | Transmit shifter takes the byte |
| tx_idle_i | input | 1 | Transmit shifter has nothing in flight |
| rx_data_i | input | 8 | Byte from the receive shifter |
| rx_valid_i | input | 1 | Receive byte available |
| rx_ready_o | output | 1 | Receive holding register empty |
| modem_i | input | 4 | Modem input levels shown in modem status |
| baud_tick_o | output | 1 | 16x baud pulse |

## Verification
The hardest case to reach from the ports is a second receive byte that arrives while the first is still unread. The bench holds `rx_valid_i` high with a different byte while the register is full. It then reads offset 0 and requires the first byte, which shows the second offer was refused. A second hard case is a divisor write that must not touch the aliased holding and enable registers. The stimulus sets the latch-access bit and writes offsets 0 and 1. It then clears the bit and checks that the line status still reports an empty transmitter and that interrupt enable still reads 0.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    OFS_DATA  = 3'd0,
    OFS_IEN   = 3'd1,
    OFS_ISTAT = 3'd2,
    OFS_LCTL  = 3'd3,
    OFS_MCTL  = 3'd4,
    OFS_LSTAT = 3'd5,
    OFS_MSTAT = 3'd6,
    OFS_SCR   = 3'd7
  } reg_ofs_e;

  localparam int LSR_DR   = 0;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int DLAB_BIT = 7;

  localparam logic [DW-1:0] ISR_NONE = 8'h01;
  localparam logic [DW-1:0] ISR_THRE = 8'h02;
  localparam logic [DW-1:0] ISR_RDA  = 8'h04;
endpackage

// File: rtl/uart_hold_reg.sv
module uart_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         clear_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (!full_o) begin
      if (load_i) begin
        full_o <= 1'b1;
        data_o <= data_i;
      end
    end else if (clear_i) begin
      full_o <= 1'b0;
    end
  end

  // R4
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> data_o == $past(data_o));

  // R3
  hold_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && clear_i |=> !full_o);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  input  logic         reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = (div_i != '0) && (cnt_q == div_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (reload_i || div_i == '0 || tick_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + W'(1);
  end

  // R6
  tick_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> tick_o == (div_i == W'(1)));

  // R6
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !reload_i && div_i > W'(1) |=> !tick_o);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  input  logic          tx_idle_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  input  logic [DW/2-1:0] modem_i,
  output logic          baud_tick_o
);
  localparam int DIV_W = 2 * DW;

  logic [DW-1:0] ien_q, lctl_q, mctl_q, scr_q, dl_lo_q, dl_hi_q;
  logic [DW-1:0] rx_byte, lsr, isr;
  logic          dlab, tx_full, rx_full;
  logic          wr_thr, wr_dll, wr_dlm, wr_ien, rd_rhr;
  reg_ofs_e      ofs;

  assign ofs    = reg_ofs_e'(addr_i);
  assign dlab   = lctl_q[DLAB_BIT];
  assign wr_thr = wr_i && ofs == OFS_DATA && !dlab;
  assign wr_dll = wr_i && ofs == OFS_DATA &&  dlab;
  assign wr_ien = wr_i && ofs == OFS_IEN  && !dlab;
  assign wr_dlm = wr_i && ofs == OFS_IEN  &&  dlab;
  assign rd_rhr = rd_i && ofs == OFS_DATA && !dlab;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q   <= '0;
      lctl_q  <= '0;
      mctl_q  <= '0;
      scr_q   <= '0;
      dl_lo_q <= '0;
      dl_hi_q <= '0;
    end else begin
      if (wr_ien)                       ien_q   <= wdata_i;
      if (wr_dll)                       dl_lo_q <= wdata_i;
      if (wr_dlm)                       dl_hi_q <= wdata_i;
      if (wr_i && ofs == OFS_LCTL)      lctl_q  <= wdata_i;
      if (wr_i && ofs == OFS_MCTL)      mctl_q  <= wdata_i;
      if (wr_i && ofs == OFS_SCR)       scr_q   <= wdata_i;
    end
  end

  uart_hold_reg #(.W(DW)) u_tx_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_thr),
    .data_i  (wdata_i),
    .clear_i (tx_ready_i),
    .full_o  (tx_full),
    .data_o  (tx_data_o)
  );

  uart_hold_reg #(.W(DW)) u_rx_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .clear_i (rd_rhr),
    .full_o  (rx_full),
    .data_o  (rx_byte)
  );

  assign tx_valid_o = tx_full;
  assign rx_ready_o = !rx_full;

  uart_baud_gen #(.W(DIV_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    ({dl_hi_q, dl_lo_q}),
    .reload_i (wr_dll || wr_dlm),
    .tick_o   (baud_tick_o)
  );

  always_comb begin
    lsr           = '0;
    lsr[LSR_DR]   = rx_full;
    lsr[LSR_THRE] = !tx_full;
    lsr[LSR_TEMT] = !tx_full && tx_idle_i;
  end

  always_comb begin
    if (ien_q[0] && rx_full)       isr = ISR_RDA;
    else if (ien_q[1] && !tx_full) isr = ISR_THRE;
    else                           isr = ISR_NONE;
  end

  always_comb begin
    unique case (ofs)
      OFS_DATA:  rdata_o = dlab ? dl_lo_q : rx_byte;
      OFS_IEN:   rdata_o = dlab ? dl_hi_q : ien_q;
      OFS_ISTAT: rdata_o = isr;
      OFS_LCTL:  rdata_o = lctl_q;
      OFS_MCTL:  rdata_o = mctl_q;
      OFS_LSTAT: rdata_o = lsr;
      OFS_MSTAT: rdata_o = {modem_i, {(DW/2){1'b0}}};
      default:   rdata_o = scr_q;
    endcase
  end

  // R4
  tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_thr && !tx_valid_o |=> tx_valid_o && tx_data_o == $past(wdata_i));

  // R3
  rx_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rhr && !rx_ready_o |=> rx_ready_o);

  // R9
  scr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ofs == OFS_SCR |=> scr_q == $past(wdata_i));

  // R2
  alias_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && dlab && !tx_valid_o |=> !tx_valid_o);
endmodule

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o, tx_data_o, rx_data_i = '0;
  logic       tx_valid_o, tx_ready_i = 1'b0, tx_idle_i = 1'b1;
  logic       rx_valid_i = 1'b0, rx_ready_o, baud_tick_o;
  logic [3:0] modem_i = 4'hA;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  uart_regfile uut (.*);

  // {req[3:0], write, addr[2:0], data[7:0], expected[7:0]}
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 1'b0, 3'd3, 8'h00, 8'h00},  // R1 line control
    {4'd1, 1'b0, 3'd1, 8'h00, 8'h00},  // R1 interrupt enable
    {4'd1, 1'b0, 3'd4, 8'h00, 8'h00},  // R1 modem control
    {4'd1, 1'b0, 3'd2, 8'h00, 8'h01},  // R1 interrupt status
    {4'd1, 1'b0, 3'd5, 8'h00, 8'h60},  // R1 line status
    {4'd1, 1'b0, 3'd7, 8'h00, 8'h00},  // R1 scratch
    {4'd11,1'b0, 3'd6, 8'h00, 8'hA0},  // R11 modem status
    {4'd9, 1'b1, 3'd7, 8'h5A, 8'h00},
    {4'd9, 1'b0, 3'd7, 8'h00, 8'h5A},  // R9
    {4'd9, 1'b1, 3'd4, 8'h13, 8'h00},
    {4'd9, 1'b0, 3'd4, 8'h00, 8'h13},
    {4'd9, 1'b0, 3'd5, 8'h00, 8'h60},
    {4'd9, 1'b1, 3'd3, 8'h83, 8'h00},
    {4'd9, 1'b0, 3'd3, 8'h00, 8'h83},
    {4'd2, 1'b1, 3'd0, 8'hC5, 8'h00},
    {4'd2, 1'b0, 3'd0, 8'h00, 8'hC5},  // R2 divisor low
    {4'd2, 1'b1, 3'd1, 8'h12, 8'h00},
    {4'd2, 1'b0, 3'd1, 8'h00, 8'h12},  // R2 divisor high
    {4'd2, 1'b0, 3'd5, 8'h00, 8'h60},  // R2 no transmit load
    {4'd2, 1'b1, 3'd3, 8'h03, 8'h00},
    {4'd2, 1'b0, 3'd1, 8'h00, 8'h00},  // R2 enable untouched
    {4'd3, 1'b0, 3'd0, 8'h00, 8'h00},  // R3 empty receive
    {4'd10,1'b1, 3'd2, 8'hFF, 8'h00},
    {4'd10,1'b0, 3'd2, 8'h00, 8'h01},  // R10
    {4'd10,1'b1, 3'd5, 8'h00, 8'h00},
    {4'd10,1'b0, 3'd5, 8'h00, 8'h60},
    {4'd10,1'b1, 3'd6, 8'hFF, 8'h00},
    {4'd10,1'b0, 3'd6, 8'h00, 8'hA0},
    {4'd2, 1'b1, 3'd3, 8'h80, 8'h00},
    {4'd2, 1'b0, 3'd0, 8'h00, 8'hC5},  // R2 divisor kept
    {4'd2, 1'b1, 3'd3, 8'h03, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 check(req, rdata_o, exp);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic tick_run(input string req, input int n, input int period);
    for (int i = 1; i <= n; i++) begin
      #1 check(req, {7'd0, baud_tick_o}, (period != 0 && i % period == 0) ? 8'd1 : 8'd0);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 handshake outputs at reset
    #1 check("R1 tx_valid", {7'd0, tx_valid_o}, 8'd0);
    check("R1 rx_ready", {7'd0, rx_ready_o}, 8'd1);
    @(negedge clk_i);
    tick_run("R7 reset divisor", 8, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][19]) wr(VEC[k][18:16], VEC[k][15:8]);
      else rd($sformatf("R%0d vec%0d", VEC[k][23:20], k), VEC[k][18:16], VEC[k][7:0]);
    end

    // R6 divisor 3, then 1
    wr(3'd3, 8'h80); wr(3'd1, 8'h00); wr(3'd0, 8'h03);
    tick_run("R6 div3", 9, 3);
    wr(3'd0, 8'h01);
    tick_run("R6 div1", 4, 1);
    // R7 divisor 0
    wr(3'd0, 8'h00);
    tick_run("R7 div0", 10, 0);
    wr(3'd3, 8'h03);

    // R4 transmit path
    wr(3'd0, 8'h3C);
    #1 check("R4 tx_valid", {7'd0, tx_valid_o}, 8'd1);
    check("R4 tx_data", tx_data_o, 8'h3C);
    rd("R4 R5 lsr full", 3'd5, 8'h00);
    wr(3'd0, 8'h99);
    #1 check("R4 ignored write", tx_data_o, 8'h3C);
    @(negedge clk_i); tx_ready_i = 1'b1; tx_idle_i = 1'b0;
    @(negedge clk_i); tx_ready_i = 1'b0;
    #1 check("R4 drained", {7'd0, tx_valid_o}, 8'd0);
    rd("R5 shifter busy", 3'd5, 8'h20);
    tx_idle_i = 1'b1;
    rd("R5 shifter idle", 3'd5, 8'h60);

    // R8 / R3 interrupt status and receive path
    wr(3'd1, 8'h02);
    rd("R8 thr empty", 3'd2, 8'h02);
    wr(3'd1, 8'h03);
    @(negedge clk_i); rx_data_i = 8'h7E; rx_valid_i = 1'b1;
    @(negedge clk_i); rx_data_i = 8'h11;
    #1 check("R3 rx_ready full", {7'd0, rx_ready_o}, 8'd0);
    @(negedge clk_i); rx_valid_i = 1'b0;
    rd("R3 lsr ready", 3'd5, 8'h61);
    rd("R8 rx priority", 3'd2, 8'h04);
    rd("R3 rx byte", 3'd0, 8'h7E);
    rd("R3 lsr cleared", 3'd5, 8'h60);
    #1 check("R3 rx_ready empty", {7'd0, rx_ready_o}, 8'd1);
    rd("R8 back to thr", 3'd2, 8'h02);
    wr(3'd1, 8'h01);
    rd("R8 none", 3'd2, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule